// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Sequencer

This block reprograms the card-interface PHY whenever the host changes bus speed mode, card clock frequency or bus width. A one-cycle `apply` strobe presents the new settings. The block compares them with a stored record of the last settings it applied. If nothing differs, it finishes at once. If the frequency is zero, it clears only the stored frequency. Otherwise it runs a short sequence:

- It programs the pads.
- It decides whether the PHY must run in bypass (slow) mode.
- If not, it gates the card clock, writes the function-control fields for the new mode, and ungates the clock.
- It sets up the data strobe.
- It hands off to an external initialization sequencer through a start/ready handshake.

`done` pulses for one cycle when a request completes. Requests that arrive while `busy` is high are ignored.

Top module: `phy_mode_sequencer`

## Requirements
- R1: After an HS400 run (mode code 10), `func_dq_ddr` is all ones, `func_cmd_ddr` is 1 and `func_dq_async` is 0.
- R2: After a DDR50 (code 7) or DDR52 (code 8) run, `func_dq_ddr` is all ones, and both `func_cmd_ddr` and `func_dq_async` are 1.
- R3: After a full run in any other mode, `func_dq_ddr` and `func_cmd_ddr` are 0 and `func_dq_async` is 1.
- R4: `slow_mode` is decided as follows:
  - It is 0 whenever `clk_above_52m` was high at the request.
  - Otherwise, in legacy mode (code 0) it copies `slow_strap`.
  - Otherwise, in SD-HS (1), MMC-HS (2), SDR12 (3) or SDR25 (4) it is `sdio_card | slow_strap`.
  - In every remaining case it is 0.
- R5: The function-control fields change only while `card_clk_en` is low. `card_clk_en` is low only while `busy` is high, and it is high again when `done` pulses.
- R6: An HS400 run does three things:
  - It sets `strobe_en`.
  - It loads `logic_timing` with 0x00AA8977.
  - It sets the strobe pad to pull-down on, pull-up off.

  Any other full run clears `strobe_en`.
- R7: In legacy mode, or when `slow_mode` ends up set, the function-control fields and strobe outputs keep their previous values and `card_clk_en` never drops.
- R8: Every run leaves the pads as follows:
  - `pad_rx_en` = 3'b111 (bit 0 DQ, bit 1 CMD, bit 2 strobe).
  - `pad_qsn_oen` = 1 and `pad_cmos` = 1.
  - CMD and DQ pull-ups are on and their pull-downs are off.
- R9: A request matching the stored frequency, width and mode issues no `init_start`. A request with frequency 0 issues no `init_start`, and it forces the next non-zero request to run.
- R10: A run ends with a one-cycle `init_start` pulse. `done` rises only after `init_ready` has been seen high at least one cycle after the pulse.
- R11: On a non-legacy run, `sdio_mode` is set to `sdio_card`. A legacy run leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apply | input | 1 | Request strobe, sampled when idle |
| timing_mode | input | 4 | Speed mode code |
| sdio_card | input | 1 | Card is an SDIO device |
| slow_strap | input | 1 | Board asks for bypass in low-speed modes |
| clk_above_52m | input | 1 | Card clock above 52 MHz |
| clk_freq | input | FREQ_W | Card clock frequency; 0 means stopped |
| bus_width | input | BW_W | Bus width code |
| init_ready | input | 1 | Init sequencer idle/complete |
| func_dq_ddr | output | LANES | Per-lane DQ DDR enables |
| func_cmd_ddr | output | 1 | CMD DDR enable |
| func_dq_async | output | 1 | DQ asynchronous sampling |
| slow_mode | output | 1 | PHY bypass mode |
| sdio_mode | output | 1 | SDIO timing mode |
| pad_rx_en | output | 3 | Receiver enables (DQ, CMD, strobe) |
| pad_qsn_oen | output | 1 | Strobe-negative output enable |
| pad_cmos | output | 1 | CMOS receiver type select |
| pad_cmd_pu | output | 1 | CMD pull-up |
| pad_cmd_pd | output | 1 | CMD pull-down |
| pad_dq_pu | output | 1 | DQ pull-up |
| pad_dq_pd | output | 1 | DQ pull-down |
| pad_qsp_pu | output | 1 | Strobe pull-up |
| pad_qsp_pd | output | 1 | Strobe pull-down |
| strobe_en | output | 1 | Data strobe enable |
| logic_timing | output | 32 | Logic timing adjust word |
| card_clk_en | output | 1 | Card clock enable |
| init_start | output | 1 | Init sequencer start pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Request complete pulse |

## Verification
The hardest situation to reach is a skip path that must leave earlier state untouched. The function-control and strobe outputs only reveal whether they were preserved if a prior full run left them in a recognisable state. The bench therefore orders its scenarios so that each one sets up the next:

- A slow-mode or legacy request always follows a full run whose outputs are known.
- The zero-frequency request sits between two identical non-zero requests, so the second one exposes whether the record was cleared.

The init responder holds ready low for a fixed span, which makes a premature `done` visible as a short run.

// File: rtl/phy_mode_sequencer.sv
module phy_mode_sequencer #(
  parameter int          FREQ_W = 32,
  parameter int          BW_W   = 2,
  parameter int          LANES  = 8,
  parameter logic [31:0] LT_VAL = 32'h00AA8977
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [3:0]        timing_mode,
  input  logic              sdio_card,
  input  logic              slow_strap,
  input  logic              clk_above_52m,
  input  logic [FREQ_W-1:0] clk_freq,
  input  logic [BW_W-1:0]   bus_width,
  input  logic              init_ready,
  output logic [LANES-1:0]  func_dq_ddr,
  output logic              func_cmd_ddr,
  output logic              func_dq_async,
  output logic              slow_mode,
  output logic              sdio_mode,
  output logic [2:0]        pad_rx_en,
  output logic              pad_qsn_oen,
  output logic              pad_cmos,
  output logic              pad_cmd_pu,
  output logic              pad_cmd_pd,
  output logic              pad_dq_pu,
  output logic              pad_dq_pd,
  output logic              pad_qsp_pu,
  output logic              pad_qsp_pd,
  output logic              strobe_en,
  output logic [31:0]       logic_timing,
  output logic              card_clk_en,
  output logic              init_start,
  output logic              busy,
  output logic              done
);
  localparam logic [3:0] M_LEGACY = 4'd0, M_SDHS = 4'd1, M_MMCHS = 4'd2,
                         M_SDR12 = 4'd3, M_SDR25 = 4'd4,
                         M_DDR50 = 4'd7, M_DDR52 = 4'd8, M_HS400 = 4'd10;

  typedef enum logic [2:0] {S_IDLE, S_PAD, S_GATE, S_FUNC, S_UNGATE, S_INIT, S_WAIT} st_t;
  st_t st;

  logic [3:0]        mode_q;
  logic              sdio_q, strap_q, hi_q;
  logic [FREQ_W-1:0] rec_freq;
  logic [BW_W-1:0]   rec_width;

  wire is_legacy = (mode_q == M_LEGACY);
  wire is_ddr    = (mode_q == M_DDR50) || (mode_q == M_DDR52);
  wire is_hs400  = (mode_q == M_HS400);
  wire low_sdr   = (mode_q == M_SDHS) || (mode_q == M_MMCHS) ||
                   (mode_q == M_SDR12) || (mode_q == M_SDR25);
  wire slow_next = !hi_q && (is_legacy ? strap_q : (low_sdr && (sdio_q || strap_q)));
  wire same_cfg  = (clk_freq == rec_freq) && (bus_width == rec_width) &&
                   (timing_mode == mode_q);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= M_LEGACY; sdio_q <= 1'b0; strap_q <= 1'b0; hi_q <= 1'b0;
      rec_freq <= '0; rec_width <= '0;
      func_dq_ddr <= '0; func_cmd_ddr <= 1'b0; func_dq_async <= 1'b0;
      slow_mode <= 1'b0; sdio_mode <= 1'b0;
      pad_rx_en <= '0; pad_qsn_oen <= 1'b0; pad_cmos <= 1'b0;
      pad_cmd_pu <= 1'b0; pad_cmd_pd <= 1'b0; pad_dq_pu <= 1'b0; pad_dq_pd <= 1'b0;
      pad_qsp_pu <= 1'b0; pad_qsp_pd <= 1'b0;
      strobe_en <= 1'b0; logic_timing <= '0;
      card_clk_en <= 1'b1; init_start <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (apply) begin
          if (clk_freq == '0) begin
            rec_freq <= '0;
            done <= 1'b1;
          end else if (same_cfg) begin
            done <= 1'b1;
          end else begin
            mode_q <= timing_mode; sdio_q <= sdio_card;
            strap_q <= slow_strap; hi_q <= clk_above_52m;
            rec_freq <= clk_freq; rec_width <= bus_width;
            st <= S_PAD;
          end
        end
        S_PAD: begin
          pad_rx_en <= 3'b111; pad_qsn_oen <= 1'b1; pad_cmos <= 1'b1;
          pad_cmd_pu <= 1'b1; pad_cmd_pd <= 1'b0;
          pad_dq_pu <= 1'b1; pad_dq_pd <= 1'b0;
          slow_mode <= slow_next;
          if (!is_legacy) sdio_mode <= sdio_q;
          st <= (is_legacy || slow_next) ? S_INIT : S_GATE;
        end
        S_GATE: begin
          card_clk_en <= 1'b0;
          st <= S_FUNC;
        end
        S_FUNC: begin
          func_dq_ddr   <= (is_hs400 || is_ddr) ? '1 : '0;
          func_cmd_ddr  <= is_hs400 || is_ddr;
          func_dq_async <= !is_hs400;
          st <= S_UNGATE;
        end
        S_UNGATE: begin
          card_clk_en <= 1'b1;
          if (is_hs400) begin
            strobe_en <= 1'b1; logic_timing <= LT_VAL;
            pad_qsp_pd <= 1'b1; pad_qsp_pu <= 1'b0;
          end else begin
            strobe_en <= 1'b0;
          end
          st <= S_INIT;
        end
        S_INIT: begin
          init_start <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: begin
          init_start <= 1'b0;
          if (!init_start && init_ready) begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [LANES+1:0] func_word = {func_dq_ddr, func_cmd_ddr, func_dq_async};

  p_func_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_word) |-> !card_clk_en);
  p_clk_off_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !card_clk_en |-> busy);
  p_lanes_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((func_dq_ddr == '0) || (func_dq_ddr == '1)) && (func_cmd_ddr == func_dq_ddr[0]));
  p_hs400_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && func_cmd_ddr && !func_dq_async) |-> (strobe_en && logic_timing == LT_VAL));
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !init_start);
endmodule

// File: tb/phy_mode_sequencer_tb.sv
module phy_mode_sequencer_tb_top;
  localparam int RDLY = 12;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic apply = 0, sdio_card = 0, slow_strap = 0, clk_above_52m = 0, init_ready;
  logic [3:0] timing_mode = 0;
  logic [31:0] clk_freq = 0;
  logic [1:0] bus_width = 0;
  logic [7:0] func_dq_ddr;
  logic func_cmd_ddr, func_dq_async, slow_mode, sdio_mode, pad_qsn_oen, pad_cmos;
  logic pad_cmd_pu, pad_cmd_pd, pad_dq_pu, pad_dq_pd, pad_qsp_pu, pad_qsp_pd;
  logic strobe_en, card_clk_en, init_start, busy, done;
  logic [2:0] pad_rx_en;
  logic [31:0] logic_timing;

  phy_mode_sequencer dut_i (.*);

  int n_chk = 0, n_fail = 0, starts = 0, gated = 0, cyc = 0;

  initial begin
    init_ready = 1;
    forever begin
      @(negedge clk);
      if (init_start) begin
        init_ready = 0;
        repeat (RDLY) @(negedge clk);
        init_ready = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (init_start) starts++;
    if (!card_clk_en) gated++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic sd, input logic st,
                     input logic hi, input logic [31:0] f, input logic [1:0] w);
    @(negedge clk);
    timing_mode = m; sdio_card = sd; slow_strap = st; clk_above_52m = hi;
    clk_freq = f; bus_width = w; apply = 1;
    starts = 0; gated = 0; cyc = 0;
    @(negedge clk);
    apply = 0;
    while (!done && cyc < 200) begin
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 200) chk("watchdog", 1, 0);
  endtask

  task automatic t_reset();
    chk("reset card_clk_en", card_clk_en, 1);
    chk("reset busy", busy, 0);
    chk("reset func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, 0);
    chk("reset strobe", strobe_en, 0);
  endtask

  task automatic t_hs400();
    run(4'd10, 0, 0, 1, 200, 2);
    chk("R1 dq_ddr", func_dq_ddr, 8'hFF);
    chk("R1 cmd_ddr", func_cmd_ddr, 1);
    chk("R1 async", func_dq_async, 0);
    chk("R6 strobe", strobe_en, 1);
    chk("R6 logic_timing", logic_timing, 32'h00AA8977);
    chk("R6 qsp pulls", {pad_qsp_pd, pad_qsp_pu}, 2'b10);
    chk("R8 rx_en", pad_rx_en, 3'b111);
    chk("R8 oen/cmos", {pad_qsn_oen, pad_cmos}, 2'b11);
    chk("R8 pulls", {pad_cmd_pu, pad_cmd_pd, pad_dq_pu, pad_dq_pd}, 4'b1010);
    chk("R5 gated during run", gated > 0, 1);
    chk("R5 clock restored", card_clk_en, 1);
    chk("R10 one start", starts, 1);
    chk("R10 waited for ready", cyc >= RDLY, 1);
  endtask

  task automatic t_ddr52();
    run(4'd8, 0, 1, 0, 52, 2);
    chk("R4 ddr52 not slow", slow_mode, 0);
    chk("R2 func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, {8'hFF, 2'b11});
    chk("R6 strobe off", strobe_en, 0);
  endtask

  task automatic t_sdr50();
    run(4'd5, 0, 0, 1, 100, 2);
    chk("R3 func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, 10'b1);
  endtask

  task automatic t_repeat_and_zero();
    run(4'd5, 0, 0, 1, 100, 2);
    chk("R9 same cfg no start", starts, 0);
    run(4'd5, 0, 0, 1, 0, 2);
    chk("R9 zero freq no start", starts, 0);
    run(4'd5, 0, 0, 1, 100, 2);
    chk("R9 rerun after zero", starts, 1);
    run(4'd5, 0, 0, 1, 100, 1);
    chk("R9 width change runs", starts, 1);
  endtask

  task automatic t_ddr50_then_legacy();
    run(4'd7, 1, 0, 1, 50, 2);
    chk("R2 ddr50 func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, {8'hFF, 2'b11});
    chk("R11 sdio set", sdio_mode, 1);
    run(4'd0, 0, 1, 0, 25, 2);
    chk("R4 legacy strap", slow_mode, 1);
    chk("R7 legacy func kept", {func_dq_ddr, func_cmd_ddr, func_dq_async}, {8'hFF, 2'b11});
    chk("R7 no gate", gated, 0);
    chk("R11 legacy holds sdio", sdio_mode, 1);
    chk("R10 legacy start", starts, 1);
    run(4'd0, 0, 0, 0, 20, 2);
    chk("R4 legacy no strap", slow_mode, 0);
    chk("R7 legacy no gate 2", gated, 0);
  endtask

  task automatic t_slow_paths();
    run(4'd10, 0, 0, 1, 200, 2);
    run(4'd2, 1, 0, 0, 26, 2);
    chk("R4 mmchs sdio slow", slow_mode, 1);
    chk("R11 sdio mode", sdio_mode, 1);
    chk("R7 slow func kept", {func_dq_ddr, func_cmd_ddr, func_dq_async}, {8'hFF, 2'b10});
    chk("R7 slow strobe kept", strobe_en, 1);
    chk("R7 slow no gate", gated, 0);
    run(4'd4, 1, 1, 1, 60, 2);
    chk("R4 fast clock not slow", slow_mode, 0);
    chk("R3 sdr25 func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, 10'b1);
    chk("R6 strobe cleared", strobe_en, 0);
    run(4'd9, 0, 1, 0, 50, 2);
    chk("R4 hs200 not slow", slow_mode, 0);
    chk("R11 sdio cleared", sdio_mode, 0);
    chk("R3 hs200 func", {func_dq_ddr, func_cmd_ddr, func_dq_async}, 10'b1);
    chk("R5 gated hs200", gated > 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_hs400();
    t_ddr52();
    t_sdr50();
    t_repeat_and_zero();
    t_ddr50_then_legacy();
    t_slow_paths();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule